// File: doc/BRIEF.md
# PCI-to-PCI Bridge Type-1 Configuration Header Registers

This block is the register file behind the type-1 configuration header of a PCI-to-PCI bridge. Configuration accesses arrive on a dword-addressed 32-bit port with four byte enables. Writes update only the writable bits of the enabled bytes. Reads are combinational from the addressed dword. The block holds the following registers:

- command
- the three bus numbers
- the secondary latency timer
- the I/O, memory and prefetchable base/limit registers together with their upper extensions
- bridge control

Identity fields, the two status words and the address-type nibbles are constants.

The forwarding-window decoder elsewhere in the chip must rebuild its windows whenever the registers that feed it change. For that reason, the block raises a one-cycle window-update strobe after any write whose enabled bytes land on the command word, on the I/O base/limit byte pair, or anywhere in the 20 bytes from the memory base through the I/O upper-16 limit. The block also raises a one-cycle secondary-bus reset pulse when a write turns the bus-reset control bit from 0 to 1. A build parameter chooses how the windows come out of reset:

- cleared, or
- closed, which means every base at its maximum and every limit at zero.

Top module: `cfgb_top`

## Requirements
- R1: After reset with the default policy, the following are all zero: the primary (0x18), secondary (0x19) and subordinate (0x1A) bus numbers, the secondary latency (0x1B), the command (0x04), bridge control (0x3E), the prefetchable upper-32 base (0x28) and limit (0x2C), the I/O upper-16 pair (0x30), and every base/limit address field. The type nibbles keep their constant values: I/O 0x1 and prefetchable 0x1.
- R2: With the closed-window reset policy (FWD_OFF_AT_RESET=1), reset leaves these values. Every base address field is all ones: I/O base byte 0x1C reads 0xF1, memory base word 0x20 reads 0xFFF0, prefetchable base word 0x24 reads 0xFFF1. Every limit field is zero. The upper-32 and upper-16 registers are zero.
- R3: Dword 0 reads {DEVICE_ID, VENDOR_ID}. Dword 2 reads {24'h060400, REV_ID}. Byte 0x0E reads {MULTI_FUNC, 7'h01}. Writes leave all of these unchanged.
- R4: The primary status word (0x06) and the secondary status word (0x1E) both read 0x00A0 (bit 5 = 66 MHz capable, bit 7 = fast back-to-back capable), and writes do not change them.
- R5: A write changes only the bytes whose enable is set. cfg_be[i] selects byte i, which is cfg_wdata[8i+7:8i].
- R6: The following bits ignore writes and read constant: the command bits outside mask 0x0147, the low nibble of every base and limit byte at 0x1C, 0x1D, 0x20, 0x22, 0x24 and 0x26, bridge-control bits 15:12, and every unimplemented dword (3, 4, 5, 13, 14 and the low half of 15 read zero apart from byte 0x0E).
- R7: In the cycle after a write, win_upd_o is high for exactly one cycle if an enabled byte lies in 0x04–0x05, 0x1C–0x1D or 0x20–0x33. It stays low for any other write, and also for a write with no byte enabled.
- R8: In the cycle after a write that turns bridge control bit 6 (bit 22 of dword 15) from 0 to 1, sec_rst_o is high for one cycle. Rewriting the bit as 1 or clearing it produces no pulse.
- R9: cfg_rdata shows the dword selected by cfg_addr in the same cycle. A write is visible to reads from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write request for this cycle |
| cfg_addr | input | 4 | Dword index into the 64-byte header |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the addressed dword |
| win_upd_o | output | 1 | One-cycle strobe: forwarding windows must be rebuilt |
| sec_rst_o | output | 1 | One-cycle secondary-bus reset pulse |

## Verification
The secondary reset is the hardest case to reach from the ports. It needs the control bit to be clear before a write that sets it, and random data sets and clears bit 22 so often that the hold-at-one and clear cases are rarely seen in a controlled order. Directed sequences therefore walk the bit through set, set again, clear and set. Random writes with random enables cover the window-overlap cases. A directed set also probes the lane boundaries: the status halves next to the command word and the I/O pair, dword 12's top byte, and dword 13.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    localparam logic [3:0]  IO_TYPE_NIB  = 4'h1;
    localparam logic [3:0]  PF_TYPE_NIB  = 4'h1;
    localparam logic [15:0] STATUS_CONST = 16'h00A0;
    localparam logic [15:0] CMD_WMASK    = 16'h0147;
    localparam int          BCTL_W       = 12;
    localparam int          SRST_BIT     = 6;

    typedef struct packed {
        logic [15:0]       cmd;
        logic [7:0]        pri_bus;
        logic [7:0]        sec_bus;
        logic [7:0]        sub_bus;
        logic [7:0]        sec_lat;
        logic [3:0]        io_base;
        logic [3:0]        io_lim;
        logic [11:0]       mem_base;
        logic [11:0]       mem_lim;
        logic [11:0]       pf_base;
        logic [11:0]       pf_lim;
        logic [31:0]       pf_base_up;
        logic [31:0]       pf_lim_up;
        logic [15:0]       io_base_up;
        logic [15:0]       io_lim_up;
        logic [BCTL_W-1:0] bctl;
    } regs_t;

    typedef struct packed {
        regs_t r;
        logic  win;
        logic  srst;
    } state_t;

    function automatic regs_t cfgb_reset(input bit closed);
        regs_t v;
        v = '0;
        if (closed) begin
            v.io_base  = '1;
            v.mem_base = '1;
            v.pf_base  = '1;
        end
        return v;
    endfunction

endpackage

// File: rtl/cfgb_win_detect.sv
module cfgb_win_detect #(
    parameter int AW        = 4,
    parameter int LANES     = 4,
    parameter int CMD_OFS   = 4,
    parameter int CMD_LEN   = 2,
    parameter int IO_OFS    = 28,
    parameter int IO_LEN    = 2,
    parameter int MEM_OFS   = 32,
    parameter int MEM_LEN   = 20
) (
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be,
    output logic             hit
);
    localparam int LW = $clog2(LANES);
    localparam int OW = AW + LW;

    logic [LANES-1:0] lane_hit;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [OW-1:0] ofs;
        assign ofs = {addr, LW'(i)};
        assign lane_hit[i] = be[i] && (
            (int'(ofs) >= CMD_OFS && int'(ofs) < CMD_OFS + CMD_LEN) ||
            (int'(ofs) >= IO_OFS  && int'(ofs) < IO_OFS  + IO_LEN)  ||
            (int'(ofs) >= MEM_OFS && int'(ofs) < MEM_OFS + MEM_LEN));
    end

    assign hit = wr && (|lane_hit);
endmodule

// File: rtl/cfgb_rise.sv
module cfgb_rise (
    input  logic lane_we,
    input  logic old_bit,
    input  logic new_bit,
    output logic rise
);
    assign rise = lane_we && !old_bit && new_bit;
endmodule

// File: rtl/cfgb_rdmux.sv
module cfgb_rdmux
    import cfgb_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID = 16'h0B21,
    parameter logic [7:0]  REV_ID    = 8'h02,
    parameter logic [7:0]  HDR_BYTE  = 8'h01
) (
    input  regs_t       r,
    input  logic [3:0]  addr,
    output logic [31:0] rdata
);
    always_comb begin
        rdata = '0;
        unique case (addr)
            4'd0:  rdata = {DEVICE_ID, VENDOR_ID};
            4'd1:  rdata = {STATUS_CONST, r.cmd};
            4'd2:  rdata = {24'h060400, REV_ID};
            4'd3:  rdata = {8'h00, HDR_BYTE, 16'h0000};
            4'd6:  rdata = {r.sec_lat, r.sub_bus, r.sec_bus, r.pri_bus};
            4'd7:  rdata = {STATUS_CONST, r.io_lim, IO_TYPE_NIB, r.io_base, IO_TYPE_NIB};
            4'd8:  rdata = {r.mem_lim, 4'h0, r.mem_base, 4'h0};
            4'd9:  rdata = {r.pf_lim, PF_TYPE_NIB, r.pf_base, PF_TYPE_NIB};
            4'd10: rdata = r.pf_base_up;
            4'd11: rdata = r.pf_lim_up;
            4'd12: rdata = {r.io_lim_up, r.io_base_up};
            4'd15: rdata = {{(16-BCTL_W){1'b0}}, r.bctl, 16'h0000};
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgb_top.sv
module cfgb_top
    import cfgb_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID        = 16'h1AB5,
    parameter logic [15:0] DEVICE_ID        = 16'h0B21,
    parameter logic [7:0]  REV_ID           = 8'h02,
    parameter bit          MULTI_FUNC       = 1'b0,
    parameter bit          FWD_OFF_AT_RESET = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_wr,
    input  logic [3:0]  cfg_addr,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        win_upd_o,
    output logic        sec_rst_o
);
    localparam logic [7:0] HDR_BYTE = {MULTI_FUNC, 7'h01};
    localparam regs_t      RST_VAL  = cfgb_reset(FWD_OFF_AT_RESET);
    localparam int         BCTL_HI  = BCTL_W - 8;

    state_t     st_d, st_q;
    logic [3:0] we;
    logic [7:0] wb [4];
    logic       win_hit;
    logic       srst_rise;

    for (genvar i = 0; i < 4; i++) begin : g_bytes
        assign we[i] = cfg_wr && cfg_be[i];
        assign wb[i] = cfg_wdata[8*i +: 8];
    end

    cfgb_win_detect u_win (
        .wr   (cfg_wr),
        .addr (cfg_addr),
        .be   (cfg_be),
        .hit  (win_hit)
    );

    cfgb_rise u_rise (
        .lane_we (we[2] && cfg_addr == 4'd15),
        .old_bit (st_q.r.bctl[SRST_BIT]),
        .new_bit (wb[2][SRST_BIT]),
        .rise    (srst_rise)
    );

    cfgb_rdmux #(
        .VENDOR_ID (VENDOR_ID),
        .DEVICE_ID (DEVICE_ID),
        .REV_ID    (REV_ID),
        .HDR_BYTE  (HDR_BYTE)
    ) u_rd (
        .r     (st_q.r),
        .addr  (cfg_addr),
        .rdata (cfg_rdata)
    );

    always_comb begin
        st_d      = st_q;
        st_d.win  = win_hit;
        st_d.srst = srst_rise;
        unique case (cfg_addr)
            4'd1: begin
                if (we[0]) st_d.r.cmd[7:0]  = wb[0] & CMD_WMASK[7:0];
                if (we[1]) st_d.r.cmd[15:8] = wb[1] & CMD_WMASK[15:8];
            end
            4'd6: begin
                if (we[0]) st_d.r.pri_bus = wb[0];
                if (we[1]) st_d.r.sec_bus = wb[1];
                if (we[2]) st_d.r.sub_bus = wb[2];
                if (we[3]) st_d.r.sec_lat = wb[3];
            end
            4'd7: begin
                if (we[0]) st_d.r.io_base = wb[0][7:4];
                if (we[1]) st_d.r.io_lim  = wb[1][7:4];
            end
            4'd8: begin
                if (we[0]) st_d.r.mem_base[3:0]  = wb[0][7:4];
                if (we[1]) st_d.r.mem_base[11:4] = wb[1];
                if (we[2]) st_d.r.mem_lim[3:0]   = wb[2][7:4];
                if (we[3]) st_d.r.mem_lim[11:4]  = wb[3];
            end
            4'd9: begin
                if (we[0]) st_d.r.pf_base[3:0]  = wb[0][7:4];
                if (we[1]) st_d.r.pf_base[11:4] = wb[1];
                if (we[2]) st_d.r.pf_lim[3:0]   = wb[2][7:4];
                if (we[3]) st_d.r.pf_lim[11:4]  = wb[3];
            end
            4'd10: begin
                for (int i = 0; i < 4; i++)
                    if (we[i]) st_d.r.pf_base_up[8*i +: 8] = wb[i];
            end
            4'd11: begin
                for (int i = 0; i < 4; i++)
                    if (we[i]) st_d.r.pf_lim_up[8*i +: 8] = wb[i];
            end
            4'd12: begin
                if (we[0]) st_d.r.io_base_up[7:0]  = wb[0];
                if (we[1]) st_d.r.io_base_up[15:8] = wb[1];
                if (we[2]) st_d.r.io_lim_up[7:0]   = wb[2];
                if (we[3]) st_d.r.io_lim_up[15:8]  = wb[3];
            end
            4'd15: begin
                if (we[2]) st_d.r.bctl[7:0]       = wb[2];
                if (we[3]) st_d.r.bctl[BCTL_W-1:8] = wb[3][BCTL_HI-1:0];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{r: RST_VAL, win: 1'b0, srst: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign win_upd_o = st_q.win;
    assign sec_rst_o = st_q.srst;

    // R7
    mem_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == 4'd8 && cfg_be != 4'd0) |=> win_upd_o);
    // R7
    win_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_upd_o |-> $past(cfg_wr));
    // R8
    srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rst_o |=> !sec_rst_o);
    // R8
    srst_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_rst_o |-> st_q.r.bctl[SRST_BIT]);
    // R4
    status_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 4'd7) |-> (cfg_rdata[31:16] == 16'h00A0));
    // R6
    mem_nib_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 4'd8) |-> (cfg_rdata[3:0] == 4'h0 && cfg_rdata[19:16] == 4'h0));
endmodule

// File: tb/cfgb_top_test.sv
`timescale 1ns/1ps
module cfgb_top_test;
    localparam logic [15:0] VID = 16'h1AB5;
    localparam logic [15:0] DID = 16'h0B21;
    localparam logic [7:0]  RID = 8'h02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rdata, rdata_off;
    logic        win, srst, win_off, srst_off;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] mdl [64];

    always #2.5 clk = ~clk;

    cfgb_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata),
        .win_upd_o(win), .sec_rst_o(srst)
    );

    cfgb_top #(.FWD_OFF_AT_RESET(1'b1)) uut_off (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_off),
        .win_upd_o(win_off), .sec_rst_o(srst_off)
    );

    function automatic logic [7:0] wmask(input int a);
        case (a)
            4: return 8'h47;
            5: return 8'h01;
            24, 25, 26, 27: return 8'hFF;
            28, 29, 32, 34, 36, 38: return 8'hF0;
            33, 35, 37, 39: return 8'hFF;
            62: return 8'hFF;
            63: return 8'h0F;
            default: return (a >= 40 && a <= 51) ? 8'hFF : 8'h00;
        endcase
    endfunction

    function automatic bit in_window(input int a);
        return (a >= 4 && a <= 5) || (a >= 28 && a <= 29) || (a >= 32 && a <= 51);
    endfunction

    function automatic logic [31:0] mdl_dw(input int d);
        return {mdl[4*d+3], mdl[4*d+2], mdl[4*d+1], mdl[4*d]};
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        mdl[0] = VID[7:0];  mdl[1] = VID[15:8];
        mdl[2] = DID[7:0];  mdl[3] = DID[15:8];
        mdl[6] = 8'hA0;     mdl[8] = RID;
        mdl[10] = 8'h04;    mdl[11] = 8'h06;
        mdl[14] = 8'h01;    mdl[30] = 8'hA0;
        mdl[28] = 8'h01;    mdl[29] = 8'h01;
        mdl[36] = 8'h01;    mdl[38] = 8'h01;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int d, input logic [3:0] be, input logic [31:0] data);
        bit exp_win;
        bit exp_rst;
        bit old_b;
        bit new_b;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = 4'(d); cfg_be = be; cfg_wdata = data;
        exp_win = 0;
        old_b = mdl[62][6];
        for (int i = 0; i < 4; i++) begin
            if (be[i]) begin
                int a;
                logic [7:0] m;
                a = 4*d + i;
                m = wmask(a);
                if (in_window(a)) exp_win = 1;
                mdl[a] = (mdl[a] & ~m) | (data[8*i +: 8] & m);
            end
        end
        new_b = mdl[62][6];
        exp_rst = be[2] && d == 15 && !old_b && new_b;
        @(negedge clk);
        cfg_wr = 1'b0;
        check("R7 window strobe", {31'd0, win}, {31'd0, exp_win});
        check("R8 secondary reset", {31'd0, srst}, {31'd0, exp_rst});
        cfg_addr = 4'(d);
        #1;
        check("R5/R6/R9 readback", rdata, mdl_dw(d));
    endtask

    task automatic read_chk(input int d, input string tag);
        @(negedge clk);
        cfg_addr = 4'(d);
        #1;
        check(tag, rdata, mdl_dw(d));
    endtask

    task automatic second_quiet(input string tag);
        @(negedge clk);
        check(tag, {30'd0, win, srst}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 / R3 / R4 reset state of every dword
        for (int d = 0; d < 16; d++) read_chk(d, "R1 R3 R4 reset dword");
        check("R1 strobes idle", {30'd0, win, srst}, 32'd0);

        // R2 closed-window policy
        @(negedge clk);
        cfg_addr = 4'd7;  #0.5; check("R2 io pair", rdata_off[15:0], 16'h01F1);
        cfg_addr = 4'd8;  #0.5; check("R2 mem pair", rdata_off, 32'h0000FFF0);
        cfg_addr = 4'd9;  #0.5; check("R2 pref pair", rdata_off, 32'h0001FFF1);
        cfg_addr = 4'd10; #0.5; check("R2 pref base upper", rdata_off, 32'h0);
        @(negedge clk);
        cfg_addr = 4'd11; #0.5; check("R2 pref limit upper", rdata_off, 32'h0);
        cfg_addr = 4'd12; #0.5; check("R2 io upper", rdata_off, 32'h0);

        // R8 directed: set, hold, clear, set
        do_write(15, 4'b0100, 32'h0040_0000);
        do_write(15, 4'b0100, 32'h0040_0000);
        do_write(15, 4'b0100, 32'h0000_0000);
        do_write(15, 4'b1100, 32'hFF40_0000);
        second_quiet("R8 pulse is one cycle");
        do_write(15, 4'b1000, 32'h0000_0000);

        // R7 directed lane boundaries
        do_write(8, 4'b0000, 32'hFFFF_FFFF);
        do_write(1, 4'b1100, 32'hFFFF_FFFF);
        do_write(7, 4'b1100, 32'hFFFF_FFFF);
        do_write(12, 4'b1000, 32'hA500_0000);
        do_write(13, 4'b1111, 32'hFFFF_FFFF);
        do_write(6, 4'b1111, 32'h1234_5678);
        second_quiet("R7 strobe is one cycle");

        // R3 / R6 writes to constant dwords
        do_write(0, 4'b1111, 32'h0);
        do_write(2, 4'b1111, 32'h0);
        do_write(3, 4'b1111, 32'hFFFF_FFFF);
        do_write(1, 4'b0011, 32'hFFFF_FFFF);
        do_write(9, 4'b1111, 32'h0000_0000);

        // R5 random byte-enabled traffic
        for (int k = 0; k < 400; k++) begin
            int d;
            d = int'($urandom_range(0, 15));
            if ($urandom_range(0, 3) == 0) d = 15;
            do_write(d, 4'($urandom_range(0, 15)), $urandom());
            read_chk(int'($urandom_range(0, 15)), "R9 random read");
        end

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule